// File: doc/BRIEF.md
# Sample Block Counter with Interrupt

This block tracks how many audio samples have been moved for playback and capture, and it raises an interrupt each time a programmed block of transfers completes. The host writes a 16-bit block length as two byte registers and sets enable bits in a configuration register. A DMA engine pulses a transfer strobe for every sample it moves. Each counter counts down and reloads itself, so blocks follow one another without the host stepping in. In ADPCM formats one transfer carries 4 bytes, so one count step stands for 4 bytes. That only changes the value the host programs, not the hardware.

In compatibility mode a single shared counter serves whichever direction is enabled, and it reports completion through one global pending bit. In extended mode, playback and capture each have their own counter and base registers. They also have their own pending flags, which a write-one-to-clear acknowledge register clears. A write of any value to the status port clears the global pending bit. The interrupt line stays high while any pending flag remains set.

Top module: `sample_block_irq`

## Requirements
- R1: After reset, irq_o, pend_o, play_pend_o and cap_pend_o are all 0, and every enable and mode bit is clear.
- R2: Register writes use index 1 for the playback base low byte and index 2 for the playback base high byte. When base B is programmed and its counter is enabled, the B+1-th enabled transfer completes a block. This holds for B=0, where every transfer completes a block, and for B values that use the high byte.
- R3: After a block completes, the counter reloads from its base on its own, and the next block again takes B+1 transfers.
- R4: The configuration register is at index 0: bit 0 enables playback, bit 1 enables capture, and bit 2 selects extended mode. A strobe whose direction is not enabled has no effect on any count or flag.
- R5: When a counter's enable goes from clear to set, the counter restarts from the full base value, and progress made before the disable is discarded. A strobe in the first enabled cycle counts as the first transfer.
- R6: Any block completion sets pend_o. A write to the status port (stat_wr_i) clears pend_o.
- R7: If a block completes in the same cycle as a status-port write, pend_o ends up set.
- R8: In compatibility mode (bit 2 clear), one counter uses the playback base and counts playback strobes while bit 0 is set and capture strobes while bit 1 is set. Its completion sets only pend_o.
- R9: In extended mode, capture uses its own base (index 3 low byte, index 4 high byte) and its own counter, and its completion sets cap_pend_o. The playback counter's completion sets play_pend_o. Both completions also set pend_o.
- R10: A write to index 5 clears play_pend_o for each data bit 0 that is set, and clears cap_pend_o for each data bit 1 that is set. Other flags are left unchanged.
- R11: irq_o is high exactly while at least one of pend_o, play_pend_o and cap_pend_o is set.
- R12: A base write while a counter is running does not change the block in progress. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register index |
| reg_data_i | input | 8 | Register write data |
| stat_wr_i | input | 1 | Status-port write, clears global pending |
| play_xfer_i | input | 1 | One playback sample transferred |
| cap_xfer_i | input | 1 | One capture sample transferred |
| irq_o | output | 1 | Interrupt request |
| pend_o | output | 1 | Global pending flag |
| play_pend_o | output | 1 | Extended-mode playback pending flag |
| cap_pend_o | output | 1 | Extended-mode capture pending flag |

## Verification
A completing strobe sets its flags, and therefore irq_o, at the same rising edge that samples it. A status or acknowledge write clears them at the edge that samples the write. An enable write reaches the configuration register at its edge, and the counter reload happens in the following cycle, where a strobe already counts. The bench drives every input on the falling edge. It advances its behavioural model at the rising edge and compares all four outputs one time unit later, so each result is checked in the cycle it is due. Directed checks at the points where a block is just short of completing or has just completed pin down the exact transfer count.

// File: rtl/sample_block_irq_pkg.sv
package sample_block_irq_pkg;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_PLAY = 0;
  localparam int unsigned DIR_CAP  = 1;

  localparam logic [IDX_W-1:0] IDX_CFG     = 3'd0;
  localparam logic [IDX_W-1:0] IDX_PB_LO   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_PB_HI   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CB_LO   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CB_HI   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_IRQ_ACK = 3'd5;

  typedef struct packed {
    logic ext;
    logic cap_en;
    logic play_en;
  } cfg_t;
endpackage

// File: rtl/sbi_regs.sv
module sbi_regs
  import sample_block_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  play_base_o,
  output logic [CNT_W-1:0]  cap_base_o,
  output logic [NUM_DIR-1:0] clr_o
);
  logic [DATA_W-1:0] pb_lo_q, pb_hi_q, cb_lo_q, cb_hi_q;
  cfg_t              cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pb_lo_q <= '0;
      pb_hi_q <= '0;
      cb_lo_q <= '0;
      cb_hi_q <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_CFG:   cfg_q   <= cfg_t'(data_i[$bits(cfg_t)-1:0]);
        IDX_PB_LO: pb_lo_q <= data_i;
        IDX_PB_HI: pb_hi_q <= data_i;
        IDX_CB_LO: cb_lo_q <= data_i;
        IDX_CB_HI: cb_hi_q <= data_i;
        default:   ;
      endcase
    end
  end

  // acknowledge register is write-one-to-clear, no storage
  assign clr_o       = (wr_i && idx_i == IDX_IRQ_ACK) ? data_i[NUM_DIR-1:0] : '0;
  assign cfg_o       = cfg_q;
  assign play_base_o = {pb_hi_q, pb_lo_q};
  assign cap_base_o  = {cb_hi_q, cb_lo_q};
endmodule

// File: rtl/sbi_counter.sv
module sbi_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] base_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, eff;
  logic             active_q, load;

  assign load   = active_i & ~active_q;
  // restart from base in the first enabled cycle; that cycle's strobe counts
  assign eff    = load ? base_i : cnt_q;
  assign done_o = active_i & strobe_i & (eff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_i;
      if (active_i) begin
        if (strobe_i) cnt_q <= (eff == '0) ? base_i : eff - 1'b1;
        else          cnt_q <= eff;
      end
    end
  end
endmodule

// File: rtl/sbi_flags.sv
module sbi_flags
  import sample_block_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_i,
  input  logic [NUM_DIR-1:0] done_i,
  input  logic               stat_wr_i,
  input  logic [NUM_DIR-1:0] clr_i,
  output logic               pend_o,
  output logic               play_pend_o,
  output logic               cap_pend_o,
  output logic               irq_o
);
  logic pend_q, play_q, cap_q;

  // a new completion wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      play_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      if (|done_i)                  pend_q <= 1'b1;
      else if (stat_wr_i)           pend_q <= 1'b0;
      if (ext_i && done_i[DIR_PLAY]) play_q <= 1'b1;
      else if (clr_i[DIR_PLAY])     play_q <= 1'b0;
      if (done_i[DIR_CAP])          cap_q  <= 1'b1;
      else if (clr_i[DIR_CAP])      cap_q  <= 1'b0;
    end
  end

  assign pend_o      = pend_q;
  assign play_pend_o = play_q;
  assign cap_pend_o  = cap_q;
  assign irq_o       = pend_q | play_q | cap_q;
endmodule

// File: rtl/sample_block_irq.sv
module sample_block_irq
  import sample_block_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              stat_wr_i,
  input  logic              play_xfer_i,
  input  logic              cap_xfer_i,
  output logic              irq_o,
  output logic              pend_o,
  output logic              play_pend_o,
  output logic              cap_pend_o
);
  cfg_t               cfg;
  logic [CNT_W-1:0]   play_base, cap_base;
  logic [NUM_DIR-1:0] flag_clr, done, active, strobe;
  logic [CNT_W-1:0]   base_v [NUM_DIR];

  sbi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .idx_i       (reg_idx_i),
    .data_i      (reg_data_i),
    .cfg_o       (cfg),
    .play_base_o (play_base),
    .cap_base_o  (cap_base),
    .clr_o       (flag_clr)
  );

  // compat: counter 0 is shared by both directions; counter 1 idle
  always_comb begin
    active[DIR_PLAY] = cfg.ext ? cfg.play_en : (cfg.play_en | cfg.cap_en);
    strobe[DIR_PLAY] = (play_xfer_i & cfg.play_en) | (~cfg.ext & cap_xfer_i & cfg.cap_en);
    active[DIR_CAP]  = cfg.ext & cfg.cap_en;
    strobe[DIR_CAP]  = cap_xfer_i;
  end

  assign base_v[DIR_PLAY] = play_base;
  assign base_v[DIR_CAP]  = cap_base;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_cnt
    sbi_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active[d]),
      .strobe_i (strobe[d]),
      .base_i   (base_v[d]),
      .done_o   (done[d])
    );
  end

  sbi_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_i       (cfg.ext),
    .done_i      (done),
    .stat_wr_i   (stat_wr_i),
    .clr_i       (flag_clr),
    .pend_o      (pend_o),
    .play_pend_o (play_pend_o),
    .cap_pend_o  (cap_pend_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/sample_block_irq_chk.sv
module sample_block_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stat_wr_i,
  input logic [1:0] done_i,
  input logic [1:0] clr_i,
  input logic       irq_o,
  input logic       pend_o,
  input logic       play_pend_o,
  input logic       cap_pend_o
);
  AST_STAT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && done_i == 2'b00) |=> !pend_o); // R6

  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> pend_o); // R7

  AST_CAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i[1] |=> cap_pend_o); // R9

  AST_PLAY_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(play_pend_o) |-> $past(done_i[0])); // R9

  AST_ACK_CLEARS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !done_i[1]) |=> !cap_pend_o); // R10

  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_wr_i && clr_i == 2'b00) |=> irq_o); // R11
endmodule

bind sample_block_irq sample_block_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_wr_i   (stat_wr_i),
  .done_i      (done),
  .clr_i       (flag_clr),
  .irq_o       (irq_o),
  .pend_o      (pend_o),
  .play_pend_o (play_pend_o),
  .cap_pend_o  (cap_pend_o)
);

// File: tb/sample_block_irq_test.sv
module sample_block_irq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [2:0] reg_idx_i = '0;
  logic [7:0] reg_data_i = '0;
  logic       stat_wr_i = 1'b0;
  logic       play_xfer_i = 1'b0;
  logic       cap_xfer_i = 1'b0;
  logic       irq_o, pend_o, play_pend_o, cap_pend_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  sample_block_irq uut (
    .clk_i, .rst_ni, .reg_wr_i, .reg_idx_i, .reg_data_i, .stat_wr_i,
    .play_xfer_i, .cap_xfer_i, .irq_o, .pend_o, .play_pend_o, .cap_pend_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference model
  int m_cnt [2];
  bit m_prev [2];
  bit [2:0] m_cfg;
  int m_pbase, m_cbase;
  bit m_pend, m_pp, m_cp;

  task automatic chk(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_prev[0] = 0; m_prev[1] = 0;
      m_cfg = 0; m_pbase = 0; m_cbase = 0; m_pend = 0; m_pp = 0; m_cp = 0;
    end else begin
      bit ext, pe, ce;
      bit act [2];
      bit stb [2];
      bit dn [2];
      int base [2];
      ext = m_cfg[2]; pe = m_cfg[0]; ce = m_cfg[1];
      act[0] = ext ? pe : (pe | ce);
      act[1] = ext & ce;
      stb[0] = (play_xfer_i & pe) | (!ext & cap_xfer_i & ce);
      stb[1] = cap_xfer_i;
      base[0] = m_pbase; base[1] = m_cbase;
      for (int d = 0; d < 2; d++) begin
        int e;
        dn[d] = 0;
        if (act[d]) begin
          e = (!m_prev[d]) ? base[d] : m_cnt[d];
          if (stb[d]) begin
            if (e == 0) begin dn[d] = 1; m_cnt[d] = base[d]; end
            else m_cnt[d] = e - 1;
          end else m_cnt[d] = e;
        end
        m_prev[d] = act[d];
      end
      if (dn[0] || dn[1]) m_pend = 1; else if (stat_wr_i) m_pend = 0;
      if (ext && dn[0]) m_pp = 1; else if (reg_wr_i && reg_idx_i == 5 && reg_data_i[0]) m_pp = 0;
      if (dn[1]) m_cp = 1; else if (reg_wr_i && reg_idx_i == 5 && reg_data_i[1]) m_cp = 0;
      if (reg_wr_i) begin
        case (reg_idx_i)
          3'd0: m_cfg = reg_data_i[2:0];
          3'd1: m_pbase = (m_pbase & 32'hFF00) | reg_data_i;
          3'd2: m_pbase = (m_pbase & 32'h00FF) | (int'(reg_data_i) << 8);
          3'd3: m_cbase = (m_cbase & 32'hFF00) | reg_data_i;
          3'd4: m_cbase = (m_cbase & 32'h00FF) | (int'(reg_data_i) << 8);
          default: ;
        endcase
      end
    end
    #1;
    if (rst_ni) begin
      chk({cur_req, "/model"}, pend_o, m_pend, "pend_o");
      chk({cur_req, "/model"}, play_pend_o, m_pp, "play_pend_o");
      chk({cur_req, "/model"}, cap_pend_o, m_cp, "cap_pend_o");
      chk("R11", irq_o, m_pend | m_pp | m_cp, "irq_o");
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [7:0] data);
    reg_wr_i = 1; reg_idx_i = idx; reg_data_i = data;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic stat();
    stat_wr_i = 1;
    @(negedge clk_i);
    stat_wr_i = 0;
  endtask

  task automatic xfer(input bit p, input bit c, input int n);
    for (int i = 0; i < n; i++) begin
      play_xfer_i = p; cap_xfer_i = c;
      @(negedge clk_i);
      play_xfer_i = 0; cap_xfer_i = 0;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", irq_o, 0, "irq_o"); chk("R1", pend_o, 0, "pend_o");
    chk("R1", play_pend_o, 0, "play_pend_o"); chk("R1", cap_pend_o, 0, "cap_pend_o");
    rst_ni = 1;
    @(negedge clk_i);
    cur_req = "R2";
    wr(1, 8'd3); wr(2, 8'd0); wr(0, 8'd1);
    xfer(1, 0, 3); chk("R2", pend_o, 0, "pend after 3 of 4");
    xfer(1, 0, 1); chk("R2", pend_o, 1, "pend after 4 of 4");
    chk("R8", play_pend_o, 0, "compat leaves play flag clear");
    cur_req = "R6";
    stat(); chk("R6", pend_o, 0, "pend after status write"); chk("R11", irq_o, 0, "irq cleared");
    cur_req = "R3";
    xfer(1, 0, 3); chk("R3", pend_o, 0, "reload block short");
    xfer(1, 0, 1); chk("R3", pend_o, 1, "reload block done");
    stat();
    cur_req = "R12";
    wr(1, 8'd1);
    xfer(1, 0, 3); chk("R12", pend_o, 0, "old base in flight");
    xfer(1, 0, 1); chk("R12", pend_o, 1, "old base completes");
    stat();
    xfer(1, 0, 1); chk("R12", pend_o, 0, "new base short");
    xfer(1, 0, 1); chk("R12", pend_o, 1, "new base done");
    stat();
    cur_req = "R4";
    xfer(1, 0, 1);
    wr(0, 8'd0);
    xfer(1, 1, 4); chk("R4", pend_o, 0, "disabled strobes ignored");
    cur_req = "R5";
    wr(0, 8'd1);
    xfer(1, 0, 1); chk("R5", pend_o, 0, "reload discards progress");
    xfer(1, 0, 1); chk("R5", pend_o, 1, "full block after re-enable");
    stat();
    cur_req = "R7";
    xfer(1, 0, 1);
    stat_wr_i = 1; play_xfer_i = 1;
    @(negedge clk_i);
    stat_wr_i = 0; play_xfer_i = 0;
    chk("R7", pend_o, 1, "set beats clear");
    stat();
    cur_req = "R8";
    wr(0, 8'd2);
    xfer(1, 0, 1); chk("R4", pend_o, 0, "play strobe with play disabled");
    xfer(0, 1, 1); chk("R8", pend_o, 0, "shared counter capture short");
    xfer(0, 1, 1); chk("R8", pend_o, 1, "shared counter capture done");
    chk("R8", cap_pend_o, 0, "compat leaves capture flag clear");
    stat();
    cur_req = "R9";
    wr(1, 8'd2); wr(3, 8'd1); wr(4, 8'd0); wr(0, 8'd0); wr(0, 8'd7);
    xfer(1, 1, 1); chk("R9", pend_o, 0, "ext none yet");
    xfer(1, 1, 1); chk("R9", cap_pend_o, 1, "capture done");
    chk("R9", play_pend_o, 0, "play not yet"); chk("R9", pend_o, 1, "global set");
    xfer(1, 1, 1); chk("R9", play_pend_o, 1, "play done");
    cur_req = "R10";
    wr(5, 8'd2); chk("R10", cap_pend_o, 0, "ack capture"); chk("R10", play_pend_o, 1, "play kept");
    stat(); chk("R10", pend_o, 0, "global cleared"); chk("R11", irq_o, 1, "irq held by play flag");
    wr(5, 8'd1); chk("R10", play_pend_o, 0, "ack play"); chk("R11", irq_o, 0, "irq low");
    cur_req = "R2";
    wr(1, 8'd0); wr(2, 8'd0); wr(0, 8'd0); wr(0, 8'd5);
    xfer(1, 0, 1); chk("R2", play_pend_o, 1, "base zero fires every transfer");
    wr(5, 8'd1); stat();
    wr(2, 8'd1); wr(0, 8'd0); wr(0, 8'd5);
    xfer(1, 0, 256); chk("R2", play_pend_o, 0, "high byte 256 of 257");
    xfer(1, 0, 1); chk("R2", play_pend_o, 1, "high byte 257 of 257");
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule